// File: doc/BRIEF.md
# SPI Mode-0 Register Access Slave

This block lets an SPI host in mode 0 read and write one location of a small register file per transfer. The host pulls chip select low, shifts in a command byte and then either shifts in one data byte (write) or receives one data byte on the serial output (read). Chip select, serial clock and serial input are brought into the system clock domain through two-flop synchronisers. Serial clock edges are then found by comparing the synchronised value with its previous sample. The register side is a simple strobe bus. A single-cycle write strobe carries address and data. A single-cycle read strobe expects the read data on the bus input in the following cycle.

The frame is always 16 bits long. The command byte is laid out as follows:

| Bit | Meaning |
|-----|---------|
| 7 | direction flag: 1 = read, 0 = write |
| 6:3 | register address |
| 2:1 | must be zero |
| 0 | ignored |

The data byte follows, most significant bit first. The controller is a four-state machine:

- `ST_IDLE`: chip select high.
- `ST_CMD`: collecting the command byte.
- `ST_DATA`: collecting or sending the data byte.
- `ST_DONE`: frame complete, extra clocks ignored.

Its transitions are:

- ST_IDLE→ST_CMD when synchronised chip select is low.
- ST_CMD→ST_DATA on the eighth rising edge.
- ST_DATA→ST_DONE on the sixteenth rising edge.
- From ST_CMD, ST_DATA and ST_DONE to ST_IDLE whenever synchronised chip select is high.

Top module: `spi_regacc_slave`

## Requirements
- R1: After reset `spi_sdo_oe`, `reg_wr`, `reg_rd` and `spi_sdo` are all low.
- R2: A frame in which chip select returns high before the sixteenth rising SCLK edge produces no write strobe, and the next frame starts again at command bit 7.
- R3: Command bit 7 = 1 selects a read and 0 selects a write. Bits 6:3 are the register address presented on `reg_addr`. Bit 0 has no effect.
- R4: If command bits 2:1 are not both zero, the frame issues neither `reg_rd` nor `reg_wr`, and `spi_sdo` stays low for the whole frame.
- R5: A complete write frame issues exactly one single-cycle `reg_wr`. It comes after the sixteenth rising edge, with `reg_wdata` equal to the data byte received most significant bit first.
- R6: A read frame issues exactly one single-cycle `reg_rd` after the eighth rising edge. It takes `reg_rdata` in the cycle after the strobe and presents the byte on `spi_sdo` MSB first. D7 is valid before the ninth rising edge, and each later bit changes only after a falling SCLK edge.
- R7: `spi_sdo_oe` is high while a frame is in progress and low once synchronised chip select is high.
- R8: If chip select rises in the same sample as the sixteenth rising SCLK edge, chip select wins and the write is discarded.
- R9: SCLK edges after the sixteenth, while chip select stays low, cause no further strobe and no change to the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| spi_cs_n | input | 1 | chip select from host, active low |
| spi_sclk | input | 1 | serial clock from host, idles low |
| spi_sdi | input | 1 | serial data from host |
| spi_sdo | output | 1 | serial data to host |
| spi_sdo_oe | output | 1 | enable for the tri-state driver of `spi_sdo` |
| reg_addr | output | 4 | register address of the current frame |
| reg_wr | output | 1 | single-cycle write strobe |
| reg_wdata | output | 8 | write data, valid with `reg_wr` |
| reg_rd | output | 1 | single-cycle read strobe |
| reg_rdata | input | 8 | read data, valid the cycle after `reg_rd` |

## Verification
Two events can land in the same system-clock sample: the final (sixteenth) SCLK rising edge that would complete a write, and the chip select release that aborts the frame. The bench raises SCLK and chip select at the same instant. It then judges by the write strobe count and by reading the register back over SPI, which must still hold its earlier value. The bench also compares this with a frame released one half-period after the last edge, which must commit. A sweep over all sixteen addresses in both directions, with varying ignored-bit values and reserved-bit patterns, checks the decode.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regacc_edge.sv
module spi_regacc_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= d;
    end

    assign rise = d & ~prev_q;
    assign fall = ~d & prev_q;
endmodule

// File: rtl/spi_regacc_ctrl.sv
module spi_regacc_ctrl
    import spi_regacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int RESV_W     = DATA_W - 2 - ADDR_W;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_FST  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS - 1);

    spi_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-2:0]   sh_q;
    logic [DATA_W-1:0]   tx_q;
    logic                wr_ok_q;
    logic                ld_q;

    // command fields, valid when the eighth bit arrives (bit 0 is on sdi_s and ignored)
    logic                cmd_rd;
    logic [ADDR_W-1:0]   cmd_addr;
    logic                cmd_ok;
    assign cmd_rd   = sh_q[DATA_W-2];
    assign cmd_addr = sh_q[DATA_W-3 -: ADDR_W];
    assign cmd_ok   = ~|sh_q[RESV_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_s) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_s)                                  state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == CMD_LAST)   state_d = ST_DATA;
            end
            ST_DATA: begin
                if (cs_s)                                  state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == FRAME_END)  state_d = ST_DONE;
            end
            ST_DONE: if (cs_s) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            wr_ok_q   <= 1'b0;
            ld_q      <= 1'b0;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            reg_rd    <= 1'b0;
            sdo_oe    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            ld_q   <= reg_rd;
            sdo_oe <= (state_d != ST_IDLE);
            if (cs_s) begin
                cnt_q   <= '0;
                tx_q    <= '0;
                wr_ok_q <= 1'b0;
            end else begin
                if (sclk_rise && (state_q == ST_CMD || state_q == ST_DATA)) begin
                    sh_q  <= {sh_q[DATA_W-3:0], sdi_s};
                    cnt_q <= cnt_q + 1'b1;
                    if (state_q == ST_CMD && cnt_q == CMD_LAST) begin
                        reg_addr <= cmd_addr;
                        wr_ok_q  <= ~cmd_rd & cmd_ok;
                        reg_rd   <= cmd_rd & cmd_ok;
                    end
                    if (state_q == ST_DATA && cnt_q == FRAME_END && wr_ok_q) begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= {sh_q, sdi_s};
                    end
                end
                if (ld_q) begin
                    tx_q <= reg_rdata;
                end else if (sclk_fall && state_q == ST_DATA && cnt_q != DATA_FST) begin
                    tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo = tx_q[DATA_W-1];

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_wr_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (state_q == ST_DONE));
    assert_rd_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (state_q == ST_DATA && cnt_q == DATA_FST));
    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> !sdo_oe);
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> (!reg_wr && !reg_rd));
endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0] pins_s;
    logic       sclk_rise, sclk_fall;

    spi_regacc_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_sdi}),
        .q     (pins_s)
    );

    spi_regacc_edge #(.RST_VAL(1'b0)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_s[1]),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    spi_regacc_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[2]),
        .sdi_s     (pins_s[0]),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdo       (spi_sdo),
        .sdo_oe    (spi_sdo_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/test_spi_regacc_slave.sv
module test_spi_regacc_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
    logic       spi_sdo, spi_sdo_oe, reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = 8'h00;
    logic [7:0] mem [16];
    int         wr_cnt = 0, rd_cnt = 0;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    spi_regacc_slave i_spi_regacc_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // register-file model on the strobe bus
    always @(posedge clk) begin
        if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
        if (reg_rd) begin reg_rdata <= mem[reg_addr]; rd_cnt <= rd_cnt + 1; end
    end

    function automatic logic [7:0] val1(input int a);
        return 8'((a * 29 + 7) & 8'hFF);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic rw, input logic [3:0] a, input logic [1:0] rs,
                         input logic lsb, input logic [7:0] d, input int nbits,
                         input logic cs_last, output logic [7:0] rx, output logic oe_mid);
        logic [15:0] w;
        w = {rw, a, rs, lsb, d};
        rx = 8'h00; oe_mid = 1'b0;
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = (i < 16) ? w[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) rx[15-i] = spi_sdo;
            if (i == 2) oe_mid = spi_sdo_oe;
            if (cs_last && i == nbits - 1) spi_cs_n = 1'b1;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic       oe;
        int         w0, r0;
        for (int a = 0; a < 16; a++) mem[a] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!spi_sdo_oe && !reg_wr && !reg_rd && !spi_sdo, "R1", {spi_sdo_oe, reg_wr, reg_rd, spi_sdo}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!spi_sdo_oe && !reg_wr && !reg_rd, "R1 after release", {spi_sdo_oe, reg_wr, reg_rd}, 0);

        // R3/R5: write all addresses, bit 0 varied
        for (int a = 0; a < 16; a++) begin
            w0 = wr_cnt;
            frame(1'b0, 4'(a), 2'b00, a[0], val1(a), 16, 1'b0, rx, oe);
            check(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
            check(oe == 1'b1, "R7 oe high in frame", oe, 1);
            check(spi_sdo_oe == 1'b0, "R7 oe low after cs", spi_sdo_oe, 0);
        end
        // R3/R6: read all addresses back, bit 0 inverted
        for (int a = 0; a < 16; a++) begin
            r0 = rd_cnt;
            frame(1'b1, 4'(a), 2'b00, ~a[0], 8'h00, 16, 1'b0, rx, oe);
            check(rx == val1(a), "R6 R3 read data", rx, val1(a));
            check(rd_cnt == r0 + 1, "R6 one read strobe", rd_cnt - r0, 1);
        end
        // R4: reserved bits non-zero in both directions
        for (int a = 0; a < 16; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            frame(1'b0, 4'(a), 2'(a % 3 + 1), 1'b0, ~val1(a), 16, 1'b0, rx, oe);
            frame(1'b1, 4'(a), 2'(a % 3 + 1), 1'b0, 8'h00, 16, 1'b0, rx, oe);
            check(wr_cnt == w0 && rd_cnt == r0, "R4 no strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
            check(rx == 8'h00, "R4 sdo low", rx, 0);
        end
        frame(1'b1, 4'd9, 2'b00, 1'b0, 8'h00, 16, 1'b0, rx, oe);
        check(rx == val1(9), "R4 value kept", rx, val1(9));

        // R2: abort after 12 bits, then a normal read must decode correctly
        w0 = wr_cnt;
        frame(1'b0, 4'd5, 2'b00, 1'b0, 8'hA5, 12, 1'b0, rx, oe);
        check(wr_cnt == w0, "R2 aborted no write", wr_cnt - w0, 0);
        frame(1'b1, 4'd5, 2'b00, 1'b0, 8'h00, 16, 1'b0, rx, oe);
        check(rx == val1(5), "R2 value kept", rx, val1(5));

        // R8: chip select rises with the sixteenth rising edge
        w0 = wr_cnt;
        frame(1'b0, 4'd6, 2'b00, 1'b0, 8'h5A, 16, 1'b1, rx, oe);
        check(wr_cnt == w0, "R8 cs wins", wr_cnt - w0, 0);
        frame(1'b1, 4'd6, 2'b00, 1'b0, 8'h00, 16, 1'b0, rx, oe);
        check(rx == val1(6), "R8 value kept", rx, val1(6));

        // R9: four extra clocks after a complete write
        w0 = wr_cnt;
        frame(1'b0, 4'd7, 2'b00, 1'b1, 8'h3C, 20, 1'b0, rx, oe);
        check(wr_cnt == w0 + 1, "R9 single write", wr_cnt - w0, 1);
        frame(1'b1, 4'd7, 2'b00, 1'b0, 8'h00, 16, 1'b0, rx, oe);
        check(rx == 8'h3C, "R9 written value", rx, 8'h3C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule